// File: doc/BRIEF.md
# Code-Cache Branch Trap Unit

This block sits beside the instruction fetch path of a core that executes position-independent code out of a direct-mapped code cache in local RAM. Software copies fixed-size chunks of a larger external program into cache slots. The slot is chosen by the external address bits just above the line offset. Because the mapping keeps the low address bits, a cache address equals the low bits of the external address. A relative jump that stays inside the resident line therefore needs no correction.

The unit remembers which external line is currently executing and which external chunk each slot holds. Every fetch request, whether it is a branch target or the next sequential word, is measured against the active line. A fetch that stays inside the line is accepted at once. A fetch that leaves the line is translated back to its external address. If the slot for that address already holds the matching chunk, the fetch is accepted and that line becomes the active one. Otherwise the fetch is stalled and a trap is raised for the handler software. The trap reports the external target, the slot that must be filled and the offset within the line. The handler fills the slot, writes its tag and acknowledges the trap. The held request is then evaluated again.

Fetch requests use a valid/ready handshake. The core must hold `fetch_valid`, `fetch_addr` and `fetch_branch` steady until `fetch_ready` is seen high. The unit lowers `fetch_ready` to apply back-pressure. A request is taken on a cycle where both signals are high. The table write port and the trap pins are plain control signals.

Top module: `cc_branch_trap`

## Requirements
- R1: After reset the trap is low, the active external line index equals the RESET_LINE parameter, and every slot is invalid.
- R2: A request whose cache address lies from the active line's cache base up to base+1023 is ready in the same cycle. Its `fetch_ext_addr` is the active line's external base plus that offset.
- R3: A valid request that leaves the active line, below its base or at or above base+1024, is not ready unless its slot is a hit. With no hit, `trap` rises on the next clock edge.
- R4: The external target is the active line's external base plus the displacement (fetch address minus cache base), taken as a signed 17-bit value. A trap reports this target, its slot (bits 16:10), its offset (bits 9:0) and `trap_by_branch` equal to `fetch_branch`.
- R5: A sequential fetch (`fetch_branch` = 0) that runs past the end of a line is handled exactly like a branch and traps with `trap_by_branch` low.
- R6: An out-of-line request whose slot is valid and whose stored tag equals target bits 23:17 is ready in the same cycle without a trap. `fetch_ext_addr` carries the target.
- R7: When such a translated request is accepted, the active external line index becomes target bits 23:10 from the next cycle. It changes at no other time.
- R8: While `trap` is high, `fetch_ready` stays low and the report fields stay stable. A `trap_ack` pulse clears `trap` at that edge, and the held request is evaluated again from the following cycle.
- R9: `trap_ack` while no trap is pending has no effect.
- R10: A table write (`tbl_we`) stores `tbl_tag` and `tbl_valid` into slot `tbl_slot`. Lookups see the new contents from the next cycle.
- R11: With `fetch_valid` low, no trap is raised and the active line does not change, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Request accepted this cycle |
| fetch_addr | input | 17 | Requested cache address |
| fetch_branch | input | 1 | 1 = branch target, 0 = sequential fetch |
| fetch_ext_addr | output | 24 | External address of the request |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_slot | input | 7 | Slot to write |
| tbl_tag | input | 7 | External tag to store |
| tbl_valid | input | 1 | Valid bit to store |
| trap_ack | input | 1 | One-cycle trap acknowledge |
| trap | output | 1 | Trap pending |
| trap_ext_addr | output | 24 | External target of the trapped fetch |
| trap_slot | output | 7 | Slot the target maps to |
| trap_offset | output | 10 | Offset of the target within its line |
| trap_by_branch | output | 1 | Trapped fetch was a branch |
| cur_line_base | output | 14 | External line index currently executing |

## Verification
The bench uses the default geometry: 24-bit external addresses, 1 KB lines and 128 slots. It overrides RESET_LINE so that execution starts in the chunk at external 0x23000, which sits in cache at 0x3000. This puts the worked case of a jump to 0x25018 within reach from the first cycle. Tags of 1 and 2 can then be stored and compared in the same slots to tell a hit from a stale chunk. Backward jumps and jumps across slot 0 exercise the signed displacement.

// File: rtl/cc_trap_pkg.sv
package cc_trap_pkg;
  typedef enum logic {
    CAUSE_FALLTHRU = 1'b0,
    CAUSE_BRANCH   = 1'b1
  } trap_cause_e;
endpackage

// File: rtl/cc_tag_table.sv
module cc_tag_table #(
  parameter int SLOT_BITS = 7,
  parameter int TAG_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_BITS-1:0] wr_slot,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic                 wr_valid,
  input  logic [SLOT_BITS-1:0] rd_slot,
  input  logic [TAG_W-1:0]     rd_tag,
  output logic                 hit
);
  localparam int SLOTS = 1 << SLOT_BITS;

  logic [SLOTS-1:0] vld;
  logic [TAG_W-1:0] tags [SLOTS];

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (wr_en && wr_slot == SLOT_BITS'(gi)) begin
        v_q <= wr_valid;
        t_q <= wr_tag;
      end
    end
    assign vld[gi]  = v_q;
    assign tags[gi] = t_q;

    // R10
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_slot == SLOT_BITS'(gi)) |=> (v_q == $past(wr_valid) && t_q == $past(wr_tag)));
  end

  assign hit = vld[rd_slot] && (tags[rd_slot] == rd_tag);
endmodule

// File: rtl/cc_line_window.sv
module cc_line_window #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BITS  = 10,
  parameter int SLOT_BITS  = 7,
  parameter int RESET_LINE = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [LINE_BITS+SLOT_BITS-1:0]  addr,
  input  logic                            advance,
  output logic                            in_line,
  output logic [ADDR_W-1:0]               ext_target,
  output logic [ADDR_W-LINE_BITS-1:0]     cur_line
);
  localparam int CACHE_AW   = LINE_BITS + SLOT_BITS;
  localparam int LINE_IDX_W = ADDR_W - LINE_BITS;
  localparam int EXT_PAD    = ADDR_W - CACHE_AW;

  logic [CACHE_AW-1:0] cache_base;
  logic [CACHE_AW-1:0] disp;
  logic [ADDR_W-1:0]   disp_sx;

  assign cache_base = {cur_line[SLOT_BITS-1:0], {LINE_BITS{1'b0}}};
  assign disp       = addr - cache_base;
  assign disp_sx    = {{EXT_PAD{disp[CACHE_AW-1]}}, disp};
  assign ext_target = {cur_line, {LINE_BITS{1'b0}}} + disp_sx;
  assign in_line    = (disp[CACHE_AW-1:LINE_BITS] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_line <= LINE_IDX_W'(RESET_LINE);
    else if (advance) cur_line <= ext_target[ADDR_W-1:LINE_BITS];
  end

  // R7
  line_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cur_line == $past(ext_target[ADDR_W-1:LINE_BITS]));
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cur_line));
endmodule

// File: rtl/cc_trap_ctrl.sv
module cc_trap_ctrl
  import cc_trap_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LINE_BITS = 10,
  parameter int SLOT_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_req,
  input  logic [ADDR_W-1:0]    target,
  input  logic                 is_branch,
  input  logic                 ack,
  output logic                 trap,
  output logic [ADDR_W-1:0]    rep_ext,
  output logic [SLOT_BITS-1:0] rep_slot,
  output logic [LINE_BITS-1:0] rep_off,
  output logic                 rep_branch
);
  trap_cause_e cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap     <= 1'b0;
      rep_ext  <= '0;
      rep_slot <= '0;
      rep_off  <= '0;
      cause_q  <= CAUSE_FALLTHRU;
    end else if (trap) begin
      if (ack) trap <= 1'b0;
    end else if (miss_req) begin
      trap     <= 1'b1;
      rep_ext  <= target;
      rep_slot <= target[LINE_BITS+SLOT_BITS-1:LINE_BITS];
      rep_off  <= target[LINE_BITS-1:0];
      cause_q  <= is_branch ? CAUSE_BRANCH : CAUSE_FALLTHRU;
    end
  end

  assign rep_branch = (cause_q == CAUSE_BRANCH);

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !ack) |=> (trap && $stable(rep_ext) && $stable(rep_slot) && $stable(rep_off)));
  // R8
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && ack) |=> !trap);
  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap && ack && !miss_req) |=> !trap);
endmodule

// File: rtl/cc_branch_trap.sv
module cc_branch_trap #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BITS  = 10,
  parameter int SLOT_BITS  = 7,
  parameter int RESET_LINE = 0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fetch_valid,
  output logic                                 fetch_ready,
  input  logic [LINE_BITS+SLOT_BITS-1:0]       fetch_addr,
  input  logic                                 fetch_branch,
  output logic [ADDR_W-1:0]                    fetch_ext_addr,
  input  logic                                 tbl_we,
  input  logic [SLOT_BITS-1:0]                 tbl_slot,
  input  logic [ADDR_W-LINE_BITS-SLOT_BITS-1:0] tbl_tag,
  input  logic                                 tbl_valid,
  input  logic                                 trap_ack,
  output logic                                 trap,
  output logic [ADDR_W-1:0]                    trap_ext_addr,
  output logic [SLOT_BITS-1:0]                 trap_slot,
  output logic [LINE_BITS-1:0]                 trap_offset,
  output logic                                 trap_by_branch,
  output logic [ADDR_W-LINE_BITS-1:0]          cur_line_base
);
  localparam int CACHE_AW = LINE_BITS + SLOT_BITS;
  localparam int TAG_W    = ADDR_W - CACHE_AW;

  logic              in_line;
  logic [ADDR_W-1:0] ext_target;
  logic              slot_hit;
  logic              pass;
  logic              advance;
  logic              miss_req;

  cc_line_window #(
    .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .SLOT_BITS(SLOT_BITS), .RESET_LINE(RESET_LINE)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .addr(fetch_addr), .advance(advance),
    .in_line(in_line), .ext_target(ext_target), .cur_line(cur_line_base)
  );

  cc_tag_table #(.SLOT_BITS(SLOT_BITS), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_slot(tbl_slot), .wr_tag(tbl_tag), .wr_valid(tbl_valid),
    .rd_slot(ext_target[CACHE_AW-1:LINE_BITS]), .rd_tag(ext_target[ADDR_W-1:CACHE_AW]),
    .hit(slot_hit)
  );

  assign pass        = in_line || slot_hit;
  assign fetch_ready = !trap && pass;
  assign advance     = fetch_valid && fetch_ready && !in_line;
  assign miss_req    = fetch_valid && !pass && !trap;
  assign fetch_ext_addr = ext_target;

  cc_trap_ctrl #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .SLOT_BITS(SLOT_BITS)) u_trap (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .target(ext_target),
    .is_branch(fetch_branch), .ack(trap_ack), .trap(trap),
    .rep_ext(trap_ext_addr), .rep_slot(trap_slot), .rep_off(trap_offset),
    .rep_branch(trap_by_branch)
  );

  // R3
  leave_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !trap) |=> trap);
  // R8
  stall_in_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !trap_ack) |=> !fetch_ready);
  // R11
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !trap) |=> (!trap && $stable(cur_line_base)));
endmodule

// File: tb/sim_cc_branch_trap.sv
`timescale 1ns/1ps
module sim_cc_branch_trap;
  localparam int AW = 24, LB = 10, SB = 7, CAW = 17, TW = 7;
  localparam int RL = 'h23000 >> 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, fetch_branch = 0, fetch_ready;
  logic [CAW-1:0] fetch_addr = '0;
  logic [AW-1:0] fetch_ext_addr, trap_ext_addr;
  logic tbl_we = 0, tbl_valid = 0, trap_ack = 0, trap, trap_by_branch;
  logic [SB-1:0] tbl_slot = '0, trap_slot;
  logic [TW-1:0] tbl_tag = '0;
  logic [LB-1:0] trap_offset;
  logic [AW-LB-1:0] cur_line_base;

  always #2.5 clk = ~clk;

  cc_branch_trap #(.ADDR_W(AW), .LINE_BITS(LB), .SLOT_BITS(SB), .RESET_LINE(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_branch(fetch_branch), .fetch_ext_addr(fetch_ext_addr),
    .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_tag(tbl_tag), .tbl_valid(tbl_valid),
    .trap_ack(trap_ack), .trap(trap), .trap_ext_addr(trap_ext_addr), .trap_slot(trap_slot),
    .trap_offset(trap_offset), .trap_by_branch(trap_by_branch), .cur_line_base(cur_line_base));

  int tests = 0, fails = 0;
  string ctx = "R1";

  // reference model state
  int mcur;
  bit mv[128];
  int mt[128];
  bit mtrap, mtbr;
  int mtext, mtslot, mtoff;
  // per-cycle expectations
  int e_ext, e_slot;
  bit e_inl, e_rdy;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic int ext_of(int a);
    int base = (mcur % 128) << 10;
    int d = (a - base) & 'h1FFFF;
    if (d >= 'h10000) d -= 'h20000;
    return ((mcur << 10) + d) & 'hFFFFFF;
  endfunction

  task automatic check();
    int base = (mcur % 128) << 10;
    int a = int'(fetch_addr);
    bit hit;
    e_ext  = ext_of(a);
    e_inl  = ((a - base) & 'h1FFFF) < 1024;
    e_slot = (e_ext >> 10) & 127;
    hit    = mv[e_slot] && (mt[e_slot] == (e_ext >> 17));
    e_rdy  = !mtrap && (e_inl || hit);
    chk(fetch_ready == e_rdy, e_inl ? "R2" : "R3/R6", fetch_ready, e_rdy);
    if (fetch_valid && e_rdy)
      chk(int'(fetch_ext_addr) == e_ext, e_inl ? "R2" : "R6", fetch_ext_addr, e_ext);
    chk(trap == mtrap, "R8", trap, mtrap);
    if (mtrap) begin
      chk(int'(trap_ext_addr) == mtext, "R4", trap_ext_addr, mtext);
      chk(int'(trap_slot) == mtslot, "R4", trap_slot, mtslot);
      chk(int'(trap_offset) == mtoff, "R4", trap_offset, mtoff);
      chk(trap_by_branch == mtbr, "R5", trap_by_branch, mtbr);
    end
    chk(int'(cur_line_base) == mcur, "R7", cur_line_base, mcur);
  endtask

  task automatic update();
    if (mtrap && trap_ack) mtrap = 0;
    else if (!mtrap && fetch_valid && !e_rdy) begin
      mtrap = 1; mtext = e_ext; mtslot = e_slot; mtoff = e_ext & 1023; mtbr = fetch_branch;
    end
    if (fetch_valid && e_rdy && !e_inl) mcur = e_ext >> 10;
    if (tbl_we) begin mv[tbl_slot] = tbl_valid; mt[tbl_slot] = int'(tbl_tag); end
  endtask

  task automatic tick();
    #1 check();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic fetch(int a, bit br);
    fetch_valid = 1; fetch_addr = CAW'(a); fetch_branch = br;
  endtask

  task automatic idle();
    fetch_valid = 0; tbl_we = 0; trap_ack = 0;
  endtask

  task automatic wr(int s, int t, bit v);
    tbl_we = 1; tbl_slot = SB'(s); tbl_tag = TW'(t); tbl_valid = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mcur = RL; mtrap = 0;
    for (int i = 0; i < 128; i++) begin mv[i] = 0; mt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state, idle
    ctx = "R1"; idle(); tick();
    chk(trap == 0, "R1", trap, 0);
    chk(int'(cur_line_base) == RL, "R1", cur_line_base, RL);

    // R2: in-line fetches at both ends of line 0x3000
    ctx = "R2"; fetch('h3000, 0); tick(); fetch('h33FC, 1); tick(); fetch('h3200, 1); tick();

    // R3 R4: branch to 0x5018 -> external 0x25018 traps
    ctx = "R3 R4"; fetch('h5018, 1); tick(); tick();
    chk(trap_slot == 7'd20 && trap_offset == 10'h018, "R4", trap_ext_addr, 'h25018);
    ctx = "R8"; tick();
    trap_ack = 1; tick(); trap_ack = 0;  // cleared, not loaded -> traps again
    tick();
    ctx = "R10"; wr(20, 1, 1); tick(); tbl_we = 0;
    ctx = "R6 R7"; trap_ack = 1; tick(); trap_ack = 0;
    tick();   // accepted -> line 0x94
    chk(int'(cur_line_base) == 'h94, "R7", cur_line_base, 'h94);

    // R9: idle acknowledge
    ctx = "R9"; idle(); trap_ack = 1; tick(); trap_ack = 0; tick();

    // R5: fall-through past end of line 0x5000
    ctx = "R5"; fetch('h53FC, 0); tick(); fetch('h5400, 0); tick(); tick();
    ctx = "R6"; wr(21, 2, 1); trap_ack = 1; tick(); tbl_we = 0; trap_ack = 0; tick(); tick();
    wr(21, 1, 1); trap_ack = 1; tick(); tbl_we = 0; trap_ack = 0; tick();
    // backward jump below base into resident slot 20
    ctx = "R3 R6 R7"; fetch('h53FC, 1); tick();
    ctx = "R10"; wr(21, 1, 0); fetch('h5010, 0); tick(); tbl_we = 0;
    fetch('h5400, 1); tick(); tick();
    wr(21, 1, 1); trap_ack = 1; tick(); tbl_we = 0; trap_ack = 0; tick();

    // R11: out-of-line address with no request
    ctx = "R11"; idle(); fetch_addr = 'h1F000; tick(); tick();

    // mixed random traffic
    ctx = "R2 R3 R4 R6 R7 R8 R10";
    for (int n = 0; n < 4000; n++) begin
      bit hold = fetch_valid && !e_rdy;
      tbl_we = 0; trap_ack = 0;
      if (!hold) begin
        if ($urandom_range(3) != 0) begin
          int off = int'($urandom_range(3583)) - 1536;
          fetch_valid = 1;
          fetch_branch = $urandom_range(1) == 1;
          fetch_addr = CAW'((((mcur % 128) << 10) + (off & ~3)) & 'h1FFFF);
        end else fetch_valid = 0;
      end
      if ($urandom_range(7) == 0)
        wr((mcur + int'($urandom_range(4)) - 2) & 127, int'($urandom_range(2)), $urandom_range(3) != 0);
      if (mtrap && $urandom_range(2) == 0) begin
        int ts = mtslot;
        if ($urandom_range(1) == 1) wr(ts, mtext >> 17, 1);
        trap_ack = 1;
      end else if (!mtrap && $urandom_range(9) == 0) trap_ack = 1;
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule